// File: doc/BRIEF.md
# Programmable-Flag Dual-Clock FIFO Controller

This block is one direction of a two-way data buffer. It moves 36-bit words from a write clock domain to a read clock domain through a dual-port storage array. The two clocks run freely and may be unrelated or the same clock. The write pointer and the read pointer cross between the domains as Gray code. Each domain computes its own status flags: empty and almost-empty on the read side, full and almost-full on the write side.

Two timing modes are available, and the mode is fixed at master reset. In standard mode the read flag reports empty and the write flag reports full. In fall-through mode the read flag reports that a word is waiting at the output, and the write flag reports that there is room for another write. In fall-through mode the first stored word moves to the output without a read request.

The almost-empty and almost-full thresholds start from one of five preset distances. Software can replace them by loading them in parallel from the data bus or by shifting them in one bit per clock. A partial reset empties the buffer but keeps the mode and the thresholds. When retransmit is enabled, a request sends the read side back to the first word written after the last reset.

Top module: `prog_flag_fifo`

## Requirements
- R1: A write with `wr_en` high while the write side is not full stores `wr_data`. Words come out in write order. In standard mode a read accepted on a read-clock edge puts its word on `rd_data` directly after that edge.
- R2: A write and a read on the same edge both take effect when the buffer is neither full nor empty.
- R3: In standard mode, `rd_flag` high means empty and `wr_flag` high means full (DEPTH words stored). A write while full is dropped, and a read while empty leaves `rd_data` unchanged.
- R4: In standard mode, with both clocks the same, `rd_flag` falls after the second edge that follows the write edge.
- R5: In fall-through mode, `rd_flag` high means a valid word is on `rd_data`, and `wr_flag` high means a write would be accepted. The first word appears without `rd_en`, after the third edge that follows its write edge. While `rd_en` is low, the word stays on `rd_data`.
- R6: `almost_empty` is high when the number of stored words is less than or equal to the almost-empty offset. It is computed in the read domain.
- R7: `almost_full` is high when the free space is less than or equal to the almost-full offset. It changes on the write edge that changes the fill level.
- R8: With programming code 0 on `cfg_prog`, both offsets come from the preset code `cfg_preset`: 0→8, 1→16, 2→64, 3→256, 4 to 7→1024.
- R9: With programming code 2 on `cfg_prog`, `off_ld` high loads the almost-empty offset from `wr_data[PW-1:0]` and the almost-full offset from `wr_data[18+PW-1:18]`, where PW = log2(DEPTH)+1. No word is written in that cycle.
- R10: With programming code 1 on `cfg_prog`, each cycle with `ser_en` high shifts the 2·PW-bit value {almost-full offset, almost-empty offset} left by one bit and places `ser_din` in bit 0. The first bit shifted in ends up as the MSB of the almost-full offset.
- R11: While `mrst_n` is low, the buffer is emptied and `cfg_fwft`, `cfg_retx`, `cfg_prog` and `cfg_preset` are latched. The offsets are set from the preset. After release, standard mode shows empty, not full, almost-empty high and almost-full low.
- R12: `prst_n` low empties the buffer and keeps the timing mode and the programmed offsets.
- R13: With `cfg_retx` latched high, an `rt` pulse moves reading back to the first word written since the last reset. Full is then counted from that word, so retained words are never overwritten. With `cfg_retx` low, `rt` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, synchronous, active low; latches the configuration |
| prst_n | input | 1 | Partial reset, synchronous, active low; keeps the configuration |
| cfg_fwft | input | 1 | Mode select sampled at master reset: 1 = fall-through |
| cfg_retx | input | 1 | Retransmit enable sampled at master reset |
| cfg_prog | input | 2 | Offset programming method sampled at master reset |
| cfg_preset | input | 3 | Preset offset code sampled at master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | 36 | Write word; also carries offsets during a parallel load |
| off_ld | input | 1 | Parallel offset load strobe |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset data bit |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| rd_en | input | 1 | Read request |
| rt | input | 1 | Retransmit request |
| rd_data | output | 36 | Read word |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Fill level at or below the almost-empty offset |

## Verification
The bench drives one clock into both ports, so every latency can be counted in whole cycles. It drives inputs just after a rising edge and samples on the following falling edge.

In standard mode, read data is due on the falling edge directly after the accepting read edge. Empty and almost-empty settle after the second edge following a write, because the pointer passes through two synchronizer stages. In fall-through mode, output-ready rises one edge later than empty would clear, since the output register loads on that edge. Almost-full and full follow a write at the same edge.

A scoreboard queue gets each accepted write. A falling-edge monitor pops the queue on the cycle after each accepted read in standard mode, and on each accepted read in fall-through mode. The flag checks sample exactly on the cycles listed above.

// File: rtl/pff_pkg.sv
// Shared definitions for the programmable-flag FIFO.
// Assumes offsets are at least 11 bits wide (DEPTH >= 1024).
package pff_pkg;

    // Offset programming method, latched at master reset.
    typedef enum logic [1:0] {
        PROG_PRESET   = 2'd0,
        PROG_SERIAL   = 2'd1,
        PROG_PARALLEL = 2'd2,
        PROG_RSVD     = 2'd3
    } prog_e;

    // Bit position of the almost-full field in a parallel load word.
    localparam int PAR_AF_LSB = 18;

    // Maps a preset code to its offset distance in words.
    function automatic logic [10:0] preset_offset(input logic [2:0] sel);
        case (sel)
            3'd0:    preset_offset = 11'd8;
            3'd1:    preset_offset = 11'd16;
            3'd2:    preset_offset = 11'd64;
            3'd3:    preset_offset = 11'd256;
            default: preset_offset = 11'd1024;
        endcase
    endfunction

endpackage

// File: rtl/pff_ptr_sync.sv
// Brings a Gray-coded pointer into another clock domain through two flops
// and converts it to binary there.
// Assumes the source changes at most one bit per source clock cycle.
module pff_ptr_sync #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;

    // Two-stage synchronizer; cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits above and at it.
    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = PW - 1; i >= 0; i--) begin
            acc        = acc ^ sync_q[i];
            bin_out[i] = acc;
        end
    end

endmodule

// File: rtl/pff_cfg.sv
// Configuration and offset registers, write clock domain.
// Latches the mode bits during master reset and loads the offsets from a
// preset. Afterwards it accepts a parallel or a serial load, depending on
// the latched method.
// Assumes the read domain uses the mode and offsets as quasi-static values:
// they change only while the FIFO is reset or idle.
module pff_cfg
    import pff_pkg::*;
#(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_retx,
    input  logic [1:0]    cfg_prog,
    input  logic [2:0]    cfg_preset,
    input  logic          off_ld,
    input  logic          ser_en,
    input  logic          ser_din,
    input  logic [PW-1:0] par_ae,
    input  logic [PW-1:0] par_af,
    output logic          fwft,
    output logic          retx,
    output logic          par_ld,
    output logic [PW-1:0] ae_off,
    output logic [PW-1:0] af_off
);
    prog_e         prog_q;
    logic          fwft_q;
    logic          retx_q;
    logic [PW-1:0] ae_q;
    logic [PW-1:0] af_q;
    logic          ser_shift;

    // Latch the mode bits while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            fwft_q <= cfg_fwft;
            retx_q <= cfg_retx;
            prog_q <= prog_e'(cfg_prog);
        end
    end

    assign par_ld    = (prog_q == PROG_PARALLEL) && off_ld;
    assign ser_shift = (prog_q == PROG_SERIAL) && ser_en;

    // Offset registers: preset at master reset, then a parallel or serial load.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            ae_q <= {{(PW-11){1'b0}}, preset_offset(cfg_preset)};
            af_q <= {{(PW-11){1'b0}}, preset_offset(cfg_preset)};
        end else if (par_ld) begin
            ae_q <= par_ae;
            af_q <= par_af;
        end else if (ser_shift) begin
            {af_q, ae_q} <= {af_q[PW-2:0], ae_q, ser_din};
        end
    end

    assign fwft   = fwft_q;
    assign retx   = retx_q;
    assign ae_off = ae_q;
    assign af_off = af_q;

    // R12: with no load in progress the offsets hold, across partial reset as well.
    a_r12_offsets_hold: assert property (@(posedge clk) disable iff (!mrst_n)
        (!par_ld && !ser_shift) |=> ($stable(ae_q) && $stable(af_q)));

endmodule

// File: rtl/pff_wr_side.sv
// Write pointer, full and almost-full logic, write clock domain.
// Assumes rd_bin_sync is the read pointer already synchronized into this
// domain. With retransmit enabled, the base for full is word zero.
module pff_wr_side #(
    parameter int DEPTH = 2048,
    parameter int AW    = 11,
    parameter int PW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          par_ld,
    input  logic          retx,
    input  logic          fwft,
    input  logic [PW-1:0] af_off,
    input  logic [PW-1:0] rd_bin_sync,
    output logic          wr_acc,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] wgray,
    output logic          wr_flag,
    output logic          almost_full
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] wptr;
    logic [PW-1:0] wptr_nxt;
    logic [PW-1:0] base;
    logic [PW-1:0] used;
    logic [PW-1:0] free;
    logic          full;

    assign base     = retx ? '0 : rd_bin_sync;
    assign used     = wptr - base;
    assign free     = DEPTH_P - used;
    assign full     = (used == DEPTH_P);
    assign wr_acc   = wr_en && !full && !par_ld;
    assign wptr_nxt = wptr + 1'b1;

    // Advance the binary pointer and its registered Gray copy on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (wr_acc) begin
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    assign waddr       = wptr[AW-1:0];
    assign wr_flag     = fwft ? !full : full;
    assign almost_full = (free <= af_off);

    // R3: a full FIFO accepts no write.
    a_r3_full_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(wptr));

    // R13: the fill level never exceeds DEPTH, so retained words are never overwritten.
    a_r13_used_bound: assert property (@(posedge clk) disable iff (!rst_n)
        used <= DEPTH_P);

    // R1: the pointer sent across the domains changes by at most one bit.
    a_r1_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

endmodule

// File: rtl/pff_rd_side.sv
// Read pointer, output register, empty and almost-empty logic, read clock
// domain. In fall-through mode the output register fills whenever it is
// free and the array holds data.
// Assumes wr_bin_sync is the write pointer already synchronized into this
// domain.
module pff_rd_side #(
    parameter int DEPTH = 2048,
    parameter int DW    = 36,
    parameter int AW    = 11,
    parameter int PW    = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rt,
    input  logic          retx,
    input  logic          fwft,
    input  logic [PW-1:0] ae_off,
    input  logic [PW-1:0] wr_bin_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          almost_empty
);
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] rptr;
    logic [PW-1:0] rptr_nxt;
    logic [PW-1:0] stored;
    logic [DW-1:0] rd_q;
    logic          ov;
    logic          mem_empty;
    logic          fetch;
    logic          rewind;

    assign mem_empty = (rptr == wr_bin_sync);
    assign rewind    = rt && retx;
    assign fetch     = !mem_empty && !rewind && (fwft ? (!ov || rd_en) : rd_en);
    assign rptr_nxt  = rptr + 1'b1;

    // Move the pointer: back to word zero on retransmit, forward on each fetch.
    always_ff @(posedge clk) begin
        if (!rst_n || rewind) begin
            rptr  <= '0;
            rgray <= '0;
        end else if (fetch) begin
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
        end
    end

    // Output data register, loaded from the array on each fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (fetch) begin
            rd_q <= mem_rdata;
        end
    end

    // Output-valid bit, used in fall-through mode.
    always_ff @(posedge clk) begin
        if (!rst_n || rewind) begin
            ov <= 1'b0;
        end else if (fetch) begin
            ov <= 1'b1;
        end else if (rd_en) begin
            ov <= 1'b0;
        end
    end

    assign stored       = (wr_bin_sync - rptr) + PW'(fwft && ov);
    assign raddr        = rptr[AW-1:0];
    assign rd_data      = rd_q;
    assign rd_flag      = fwft ? ov : mem_empty;
    assign almost_empty = (stored <= ae_off);

    // R3: in standard mode a read of an empty FIFO moves nothing.
    a_r3_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && mem_empty && !rewind) |=> ($stable(rptr) && $stable(rd_q)));

    // R5: a presented word stays valid and unchanged until it is read.
    a_r5_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && ov && !rd_en && !rewind) |=> (ov && $stable(rd_q)));

    // R6: the read side never sees more than DEPTH words in the array.
    a_r6_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bin_sync - rptr) <= DEPTH_P);

endmodule

// File: rtl/prog_flag_fifo.sv
// Top of the programmable-flag dual-clock FIFO. Connects the configuration
// block, the two pointer sides, the two pointer synchronizers and the
// storage array.
// Assumes each reset is held low for at least three cycles of the slower
// clock. DEPTH must be a power of two from 2048 up to 131072.
module prog_flag_fifo
    import pff_pkg::*;
#(
    parameter int DW    = 36,
    parameter int DEPTH = 2048
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          cfg_fwft,
    input  logic          cfg_retx,
    input  logic [1:0]    cfg_prog,
    input  logic [2:0]    cfg_preset,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          off_ld,
    input  logic          ser_en,
    input  logic          ser_din,
    output logic          wr_flag,
    output logic          almost_full,
    input  logic          rd_en,
    input  logic          rt,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          almost_empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          rst_n;
    logic          fwft;
    logic          retx;
    logic          par_ld;
    logic [PW-1:0] ae_off;
    logic [PW-1:0] af_off;
    logic          wr_acc;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wbin_at_rd;
    logic [PW-1:0] rbin_at_wr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem [DEPTH];

    assign rst_n = mrst_n && prst_n;

    pff_cfg #(.PW(PW)) u_cfg (
        .clk        (wr_clk),
        .mrst_n     (mrst_n),
        .cfg_fwft   (cfg_fwft),
        .cfg_retx   (cfg_retx),
        .cfg_prog   (cfg_prog),
        .cfg_preset (cfg_preset),
        .off_ld     (off_ld),
        .ser_en     (ser_en),
        .ser_din    (ser_din),
        .par_ae     (wr_data[PW-1:0]),
        .par_af     (wr_data[PAR_AF_LSB +: PW]),
        .fwft       (fwft),
        .retx       (retx),
        .par_ld     (par_ld),
        .ae_off     (ae_off),
        .af_off     (af_off)
    );

    pff_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
        .clk         (wr_clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .par_ld      (par_ld),
        .retx        (retx),
        .fwft        (fwft),
        .af_off      (af_off),
        .rd_bin_sync (rbin_at_wr),
        .wr_acc      (wr_acc),
        .waddr       (waddr),
        .wgray       (wgray),
        .wr_flag     (wr_flag),
        .almost_full (almost_full)
    );

    pff_ptr_sync #(.PW(PW)) u_w2r (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .gray_in (wgray),
        .bin_out (wbin_at_rd)
    );

    pff_ptr_sync #(.PW(PW)) u_r2w (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .gray_in (rgray),
        .bin_out (rbin_at_wr)
    );

    pff_rd_side #(.DEPTH(DEPTH), .DW(DW), .AW(AW), .PW(PW)) u_rd (
        .clk          (rd_clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .rt           (rt),
        .retx         (retx),
        .fwft         (fwft),
        .ae_off       (ae_off),
        .wr_bin_sync  (wbin_at_rd),
        .mem_rdata    (mem_rdata),
        .raddr        (raddr),
        .rgray        (rgray),
        .rd_data      (rd_data),
        .rd_flag      (rd_flag),
        .almost_empty (almost_empty)
    );

    // Storage array: written in the write domain, read without a clock.
    always_ff @(posedge wr_clk) begin
        if (wr_acc) begin
            mem[waddr] <= wr_data;
        end
    end

    assign mem_rdata = mem[raddr];

endmodule

// File: tb/tb_prog_flag_fifo.sv
// Scoreboard bench: writes push expected words into a queue, and a monitor
// on the falling edge pops and compares them as reads complete.
module tb_prog_flag_fifo;
    localparam int DW    = 36;
    localparam int DEPTH = 2048;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic          cfg_fwft = 1'b0, cfg_retx = 1'b0;
    logic [1:0]    cfg_prog = 2'd0;
    logic [2:0]    cfg_preset = 3'd0;
    logic          wr_en = 1'b0, off_ld = 1'b0, ser_en = 1'b0, ser_din = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0, rt = 1'b0;
    logic          wr_flag, almost_full, rd_flag, almost_empty;
    logic [DW-1:0] rd_data;

    int            n_chk = 0;
    int            n_err = 0;
    int            dseq  = 0;
    bit            fwft_mode = 1'b0;
    bit            std_pend  = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #2 clk = ~clk;

    prog_flag_fifo #(.DW(DW), .DEPTH(DEPTH)) dut (
        .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .cfg_fwft(cfg_fwft), .cfg_retx(cfg_retx), .cfg_prog(cfg_prog),
        .cfg_preset(cfg_preset), .wr_en(wr_en), .wr_data(wr_data),
        .off_ld(off_ld), .ser_en(ser_en), .ser_din(ser_din),
        .wr_flag(wr_flag), .almost_full(almost_full), .rd_en(rd_en), .rt(rt),
        .rd_data(rd_data), .rd_flag(rd_flag), .almost_empty(almost_empty)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic samp();
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] nxt();
        dseq++;
        return {4'h5, 32'(dseq * 7 + 3)};
    endfunction

    task automatic write_word(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d; exp_q.push_back(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic write_raw(input logic [DW-1:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic read_word();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic mreset(input bit fw, input bit rx, input logic [1:0] pg, input logic [2:0] ps);
        mrst_n = 1'b0; cfg_fwft = fw; cfg_retx = rx; cfg_prog = pg; cfg_preset = ps;
        repeat (3) tick();
        mrst_n = 1'b1; cfg_fwft = 1'b0; cfg_retx = 1'b0; cfg_prog = 2'd0; cfg_preset = 3'd0;
        exp_q.delete();
        tick();
    endtask

    // Monitor: compares read data against the scoreboard queue.
    always @(negedge clk) begin
        if (std_pend) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R1 act=%h exp=none (queue empty)", rd_data);
            end else begin
                chk("R1 std read order", rd_data, exp_q.pop_front());
            end
        end
        std_pend = !fwft_mode && rd_en && !rd_flag;
        if (fwft_mode && rd_en && rd_flag) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R5 act=%h exp=none (queue empty)", rd_data);
            end else begin
                chk("R5 fwft read order", rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [DW-1:0] a0;
        logic [DW-1:0] keep[5];
        logic [23:0]   svec;

        // Phase A: standard mode, preset code 1 (offsets 16).
        mreset(1'b0, 1'b0, 2'd0, 3'd1);
        samp();
        chk("R11 reset empty", 36'(rd_flag), 36'(1));
        chk("R11 reset not full", 36'(wr_flag), 36'(0));
        chk("R11 reset ae", 36'(almost_empty), 36'(1));
        chk("R11 reset af", 36'(almost_full), 36'(0));
        tick();
        a0 = nxt();
        write_word(a0);
        samp(); chk("R4 empty after k", 36'(rd_flag), 36'(1)); tick();
        samp(); chk("R4 empty after k+1", 36'(rd_flag), 36'(1)); tick();
        samp(); chk("R4 empty clear after k+2", 36'(rd_flag), 36'(0)); tick();
        read_word();
        samp(); chk("R3 empty after last read", 36'(rd_flag), 36'(1)); tick();
        read_word();
        repeat (2) tick();
        samp(); chk("R3 read of empty ignored", rd_data, a0); tick();
        for (int i = 0; i < 16; i++) write_word(nxt());
        repeat (3) tick();
        samp(); chk("R6 ae at 16 words", 36'(almost_empty), 36'(1)); tick();
        write_word(nxt());
        repeat (3) tick();
        samp(); chk("R6 ae off at 17 words", 36'(almost_empty), 36'(0));
        chk("R8 preset 16 on af (free 2031)", 36'(almost_full), 36'(0)); tick();
        for (int i = 0; i < 2014; i++) write_word(nxt());
        samp(); chk("R7 af off at free 17", 36'(almost_full), 36'(0)); tick();
        write_word(nxt());
        samp(); chk("R7 af on at free 16", 36'(almost_full), 36'(1)); tick();
        for (int i = 0; i < 16; i++) write_word(nxt());
        samp(); chk("R3 full at DEPTH", 36'(wr_flag), 36'(1)); tick();
        write_raw(36'hBAD_BAD_BAD);
        samp(); chk("R3 still full after dropped write", 36'(wr_flag), 36'(1)); tick();
        for (int i = 0; i < DEPTH; i++) read_word();
        repeat (3) tick();
        samp();
        chk("R3 drained, dropped word absent", 36'(exp_q.size()), 36'(0));
        chk("R3 empty after drain", 36'(rd_flag), 36'(1)); tick();

        // R2: simultaneous read and write on the same edge.
        for (int i = 0; i < 4; i++) write_word(nxt());
        repeat (3) tick();
        for (int i = 0; i < 50; i++) begin
            wr_en = 1'b1; wr_data = nxt(); exp_q.push_back(wr_data); rd_en = 1'b1;
            tick();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) tick();
        samp(); chk("R2 four words left after stream", 36'(exp_q.size()), 36'(4)); tick();
        for (int i = 0; i < 4; i++) read_word();
        repeat (3) tick();
        samp(); chk("R2 all streamed words read", 36'(exp_q.size()), 36'(0)); tick();

        // R13: rt ignored without retransmit enabled.
        rt = 1'b1; tick(); rt = 1'b0;
        repeat (3) tick();
        samp(); chk("R13 rt ignored when disabled", 36'(rd_flag), 36'(1)); tick();

        // Phase B: parallel load, almost-empty 3, almost-full 5.
        mreset(1'b0, 1'b0, 2'd2, 3'd4);
        off_ld = 1'b1; wr_en = 1'b1; wr_data = (36'(5) << 18) | 36'(3);
        tick();
        off_ld = 1'b0; wr_en = 1'b0;
        repeat (3) tick();
        samp(); chk("R9 no write during load", 36'(rd_flag), 36'(1)); tick();
        for (int i = 0; i < 3; i++) write_word(nxt());
        repeat (3) tick();
        samp(); chk("R9 ae at 3 words", 36'(almost_empty), 36'(1)); tick();
        write_word(nxt());
        repeat (3) tick();
        samp(); chk("R9 ae off at 4 words", 36'(almost_empty), 36'(0)); tick();
        for (int i = 0; i < 4; i++) read_word();
        repeat (3) tick();

        // Phase C: serial load, almost-full 7, almost-empty 2; then partial reset.
        mreset(1'b0, 1'b0, 2'd1, 3'd4);
        svec = {12'd7, 12'd2};
        for (int i = 23; i >= 0; i--) begin
            ser_en = 1'b1; ser_din = svec[i];
            tick();
        end
        ser_en = 1'b0;
        for (int i = 0; i < 2; i++) write_word(nxt());
        repeat (3) tick();
        samp(); chk("R10 ae at 2 words", 36'(almost_empty), 36'(1)); tick();
        write_word(nxt());
        repeat (3) tick();
        samp(); chk("R10 ae off at 3 words", 36'(almost_empty), 36'(0)); tick();
        prst_n = 1'b0; repeat (3) tick(); prst_n = 1'b1;
        exp_q.delete();
        tick();
        samp(); chk("R12 empty after partial reset", 36'(rd_flag), 36'(1)); tick();
        for (int i = 0; i < 2; i++) write_word(nxt());
        repeat (3) tick();
        samp(); chk("R12 ae offset kept at 2 words", 36'(almost_empty), 36'(1)); tick();
        write_word(nxt());
        repeat (3) tick();
        samp(); chk("R12 ae offset kept at 3 words", 36'(almost_empty), 36'(0)); tick();
        for (int i = 0; i < 3; i++) read_word();
        repeat (3) tick();

        // Phase D: fall-through mode.
        mreset(1'b1, 1'b0, 2'd0, 3'd0);
        fwft_mode = 1'b1;
        samp();
        chk("R5 reset not ready", 36'(rd_flag), 36'(0));
        chk("R5 reset input ready", 36'(wr_flag), 36'(1)); tick();
        a0 = nxt();
        write_word(a0);
        samp(); chk("R5 not ready after k", 36'(rd_flag), 36'(0)); tick();
        samp(); chk("R5 not ready after k+1", 36'(rd_flag), 36'(0)); tick();
        samp(); chk("R5 not ready after k+2", 36'(rd_flag), 36'(0)); tick();
        samp();
        chk("R5 ready after k+3", 36'(rd_flag), 36'(1));
        chk("R5 word falls through", rd_data, a0); tick();
        for (int i = 0; i < 5; i++) write_word(nxt());
        repeat (4) tick();
        for (int i = 0; i < 6; i++) read_word();
        repeat (4) tick();
        samp();
        chk("R5 all fwft words read", 36'(exp_q.size()), 36'(0));
        chk("R5 not ready when drained", 36'(rd_flag), 36'(0)); tick();
        prst_n = 1'b0; repeat (3) tick(); prst_n = 1'b1; tick();
        samp();
        chk("R12 fwft kept: not ready", 36'(rd_flag), 36'(0));
        chk("R12 fwft kept: input ready", 36'(wr_flag), 36'(1)); tick();
        fwft_mode = 1'b0;

        // Phase E: retransmit enabled.
        mreset(1'b0, 1'b1, 2'd0, 3'd0);
        for (int i = 0; i < 5; i++) begin
            keep[i] = nxt();
            write_word(keep[i]);
        end
        repeat (3) tick();
        for (int i = 0; i < 5; i++) read_word();
        repeat (2) tick();
        rt = 1'b1; tick(); rt = 1'b0;
        for (int i = 0; i < 5; i++) exp_q.push_back(keep[i]);
        repeat (2) tick();
        samp(); chk("R13 data again after rt", 36'(rd_flag), 36'(0)); tick();
        for (int i = 0; i < 5; i++) read_word();
        repeat (3) tick();
        samp(); chk("R13 retransmitted words read", 36'(exp_q.size()), 36'(0)); tick();
        for (int i = 0; i < DEPTH - 5; i++) write_word(nxt());
        for (int i = 0; i < 10; i++) read_word();
        repeat (4) tick();
        samp(); chk("R13 full kept after reads", 36'(wr_flag), 36'(1)); tick();
        write_raw(36'h0DEAD_BEEF);
        for (int i = 0; i < 5; i++) read_word();
        repeat (3) tick();
        samp(); chk("R13 queue order intact", 36'(exp_q.size()), 36'(DEPTH - 5 - 15));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule